// File: doc/BRIEF.md
# Dual-Code Systematic Reed-Solomon Encoder

This block encodes a stream of 10-bit symbols with a systematic Reed-Solomon code over GF(2^10), built on the field polynomial x^10 + x^3 + 1. Every codeword carries 514 message symbols. A per-codeword select picks one of two codes. The light code appends 14 check symbols, giving a 528-symbol codeword that corrects up to 7 symbol errors. The strong code appends 30 check symbols, giving a 544-symbol codeword that corrects up to 15. Both codes share one shift-register datapath with constant field multipliers. The generator roots are alpha^0 up to alpha^(P-1), where P is the number of check symbols.

Message symbols pass straight from input to output in the same cycle. Once the last message symbol has been accepted, the encoder stops taking input and emits the check symbols one per cycle, highest-degree coefficient first. Both sides use a valid/ready handshake. The input carries a start marker. The end of the message is fixed by the 514-symbol count. The output carries a start marker and an end marker.

Top module: `rs_dual_encoder`

## Requirements
- R1: After a synchronous reset, including one asserted in the middle of a codeword, out_valid is 0 and the block is idle, waiting for a start-marked symbol. The next codeword is encoded from a cleared state.
- R2: While idle or in the message phase, in_ready equals out_ready. Each accepted message symbol appears on out_data in the same cycle, unchanged and in order. out_sop is 1 only on the first message symbol.
- R3: in_mode is sampled only with the start-marked symbol. Changing it later in the codeword changes neither the parity count nor the parity values.
- R4: With in_mode = 0, exactly 14 check symbols follow the message. They are the coefficients of x^14·M(x) mod G(x), where G has roots alpha^0..alpha^13 and alpha = x. The x^13 coefficient comes first and the message's first symbol is the highest-degree coefficient of M.
- R5: With in_mode = 1, exactly 30 check symbols follow, computed the same way with roots alpha^0..alpha^29.
- R6: The check symbols follow the last message symbol with no idle cycle while out_ready is 1. Throughout the check phase, in_ready is 0 and out_valid is 1.
- R7: When out_ready is 0 during the check phase, out_data holds its value and the sequence does not advance.
- R8: out_eop is 1 only on the last check symbol, so a codeword is 528 (mode 0) or 544 (mode 1) output transfers long.
- R9: While idle, input symbols without in_sop are accepted and discarded. They produce no output and do not affect the next codeword.
- R10: An in_sop seen in the middle of a message is ignored.
- R11: Each codeword starts from cleared registers, so back-to-back codewords encode independently.
- R12: Every emitted codeword, read as a polynomial with the first symbol highest, evaluates to zero at each generator root of its mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can accept an input symbol |
| in_sop | input | 1 | Input symbol is the first of a codeword |
| in_mode | input | 1 | Code select, 0 = 14 check symbols, 1 = 30 |
| in_data | input | 10 | Input message symbol |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream accepts the output symbol |
| out_sop | output | 1 | First symbol of an output codeword |
| out_eop | output | 1 | Last symbol of an output codeword |
| out_data | output | 10 | Output symbol (message or check) |

## Verification
The hardest state to reach from the ports is a check-phase stall. Output backpressure must land after the 514th message symbol, while input is already blocked. On top of that, a mode change or a stray start marker has to be pending at the same time. Table rows apply periodic out_ready gaps, so stalls fall on both message and check cycles. Directed runs flip in_mode right after the start symbol, insert a second start marker at symbol 100, and reset in the middle of a message. Each result is compared against a long-division model and against evaluation at every generator root.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;

    localparam int SYM_W   = 10;
    localparam logic [SYM_W-1:0] FIELD_LOW = 10'h009;  // x^10 = x^3 + 1
    localparam int GEN_CAP = 64;

    typedef enum logic [1:0] {PH_IDLE, PH_MSG, PH_PAR} phase_e;

    function automatic logic [SYM_W-1:0] gf_mul(logic [SYM_W-1:0] a, logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_LOW) : (sh << 1);
        end
        return acc;
    endfunction

    // coefficient idx of prod_{r<npar} (x + alpha^r), ascending order
    function automatic logic [SYM_W-1:0] gen_coef(int npar, int idx);
        logic [SYM_W-1:0] g [0:GEN_CAP];
        logic [SYM_W-1:0] root;
        for (int i = 0; i <= GEN_CAP; i++) g[i] = '0;
        g[0] = 10'd1;
        root = 10'd1;
        for (int r = 0; r < npar; r++) begin
            for (int i = GEN_CAP; i >= 1; i--) begin
                if (i <= npar) g[i] = g[i-1] ^ gf_mul(g[i], root);
            end
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, 10'd2);
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rsenc_taps.sv
module rsenc_taps
    import rsenc_pkg::*;
#(
    parameter int PAR_A = 14,
    parameter int PAR_B = 30
) (
    input  logic [SYM_W-1:0]            fb,
    input  logic                        mode,
    output logic [PAR_B-1:0][SYM_W-1:0] prod
);
    for (genvar i = 0; i < PAR_B; i++) begin : g_tap
        localparam logic [SYM_W-1:0] CA = (i < PAR_A) ? gen_coef(PAR_A, i) : '0;
        localparam logic [SYM_W-1:0] CB = gen_coef(PAR_B, i);
        logic [SYM_W-1:0] pa;
        logic [SYM_W-1:0] pb;
        always_comb begin
            pa      = gf_mul(fb, CA);
            pb      = gf_mul(fb, CB);
            prod[i] = mode ? pb : pa;
        end
    end
endmodule

// File: rtl/rsenc_lfsr.sv
module rsenc_lfsr
    import rsenc_pkg::*;
#(
    parameter int PAR_A = 14,
    parameter int PAR_B = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             feed,
    input  logic             shift,
    input  logic             mode,
    input  logic [SYM_W-1:0] sym,
    output logic [SYM_W-1:0] top
);
    typedef struct packed {
        logic [PAR_B-1:0][SYM_W-1:0] r;
    } lfsr_t;

    lfsr_t lf_d, lf_q;
    logic [PAR_B-1:0][SYM_W-1:0] base;
    logic [PAR_B-1:0][SYM_W-1:0] prod;
    logic [SYM_W-1:0]            fb;

    rsenc_taps #(.PAR_A(PAR_A), .PAR_B(PAR_B)) u_taps (
        .fb   (fb),
        .mode (mode),
        .prod (prod)
    );

    always_comb begin
        base = clr ? '0 : lf_q.r;
        top  = mode ? base[PAR_B-1] : base[PAR_A-1];
        fb   = feed ? (sym ^ top) : '0;
        lf_d = lf_q;
        if (feed || shift) begin
            for (int i = 0; i < PAR_B; i++) begin
                lf_d.r[i] = ((i == 0) ? '0 : base[(i == 0) ? 0 : i-1]) ^ prod[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lf_q <= '0;
        else     lf_q <= lf_d;
    end

    // R7: idle register bank keeps the remainder
    a_r7_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (!feed && !shift) |=> $stable(lf_q));

    // R11: the lowest stage receives zero while check symbols drain
    a_r11_drain_zero: assert property (@(posedge clk) disable iff (rst)
        (shift && !feed) |=> (lf_q.r[0] == '0));
endmodule

// File: rtl/rsenc_seq.sv
module rsenc_seq
    import rsenc_pkg::*;
#(
    parameter int MSG_LEN = 514,
    parameter int PAR_A   = 14,
    parameter int PAR_B   = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sop,
    input  logic in_mode,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic out_sop,
    output logic out_eop,
    output logic feed,
    output logic shift,
    output logic clr,
    output logic mode_eff,
    output logic par_phase
);
    localparam int CW = $clog2(MSG_LEN);
    localparam int PW = $clog2(PAR_B);
    localparam logic [CW-1:0] LAST_MSG = CW'(MSG_LEN - 1);
    localparam logic [PW-1:0] LAST_A   = PW'(PAR_A - 1);
    localparam logic [PW-1:0] LAST_B   = PW'(PAR_B - 1);

    typedef struct packed {
        phase_e        phase;
        logic          mode;
        logic [CW-1:0] cnt;
        logic [PW-1:0] pcnt;
    } seq_t;

    seq_t s_d, s_q;
    logic acc, start;
    logic [PW-1:0] last_par;

    always_comb begin
        s_d       = s_q;
        in_ready  = (s_q.phase != PH_PAR) && out_ready;
        acc       = in_valid && in_ready;
        start     = acc && (s_q.phase == PH_IDLE) && in_sop;
        feed      = start || (acc && (s_q.phase == PH_MSG));
        par_phase = (s_q.phase == PH_PAR);
        clr       = (s_q.phase == PH_IDLE);
        mode_eff  = clr ? in_mode : s_q.mode;
        last_par  = s_q.mode ? LAST_B : LAST_A;
        shift     = par_phase && out_ready;
        out_valid = feed || par_phase;
        out_sop   = start;
        out_eop   = par_phase && (s_q.pcnt == last_par);
        case (s_q.phase)
            PH_IDLE: if (start) begin
                s_d.mode  = in_mode;
                s_d.cnt   = CW'(1);
                s_d.pcnt  = '0;
                s_d.phase = PH_MSG;
            end
            PH_MSG: if (feed) begin
                if (s_q.cnt == LAST_MSG) begin
                    s_d.phase = PH_PAR;
                    s_d.pcnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            PH_PAR: if (out_ready) begin
                if (s_q.pcnt == last_par) s_d.phase = PH_IDLE;
                else                      s_d.pcnt  = s_q.pcnt + PW'(1);
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{phase: PH_IDLE, mode: 1'b0, cnt: '0, pcnt: '0};
        else     s_q <= s_d;
    end

    // R6: last message symbol is followed directly by a check symbol
    a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_MSG && feed && s_q.cnt == LAST_MSG) |=> (out_valid && !in_ready));

    // R7: a stalled check symbol does not advance
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (par_phase && !out_ready) |=> (par_phase && $stable(s_q.pcnt)));

    // R3: the latched code select stays fixed after the start symbol
    a_r3_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase != PH_IDLE) |=> $stable(s_q.mode));

    // R8: a transferred end marker returns the block to idle
    a_r8_eop_idle: assert property (@(posedge clk) disable iff (rst)
        (out_eop && out_ready) |=> (s_q.phase == PH_IDLE));

    // R2: start and end markers never coincide
    a_r2_marker_excl: assert property (@(posedge clk) disable iff (rst)
        !(out_sop && out_eop));
endmodule

// File: rtl/rs_dual_encoder.sv
module rs_dual_encoder
    import rsenc_pkg::*;
#(
    parameter int MSG_LEN = 514,
    parameter int PAR_A   = 14,
    parameter int PAR_B   = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sop,
    input  logic             in_mode,
    input  logic [SYM_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sop,
    output logic             out_eop,
    output logic [SYM_W-1:0] out_data
);
    logic feed, shift, clr, mode_eff, par_phase;
    logic [SYM_W-1:0] top;

    rsenc_seq #(.MSG_LEN(MSG_LEN), .PAR_A(PAR_A), .PAR_B(PAR_B)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_mode   (in_mode),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .feed      (feed),
        .shift     (shift),
        .clr       (clr),
        .mode_eff  (mode_eff),
        .par_phase (par_phase)
    );

    rsenc_lfsr #(.PAR_A(PAR_A), .PAR_B(PAR_B)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .feed  (feed),
        .shift (shift),
        .mode  (mode_eff),
        .sym   (in_data),
        .top   (top)
    );

    always_comb out_data = par_phase ? top : in_data;

    // R2: a message-phase output carries the input symbol
    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !par_phase) |-> (out_data == in_data && in_valid));
endmodule

// File: tb/rs_dual_encoder_test.sv
`timescale 1ns/1ps
module rs_dual_encoder_test;
    localparam int K  = 514;
    localparam int NM = 544;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sop = 1'b0, in_mode = 1'b0, out_ready = 1'b1;
    logic [9:0] in_data = '0;
    logic in_ready, out_valid, out_sop, out_eop;
    logic [9:0] out_data;

    always #4 clk = ~clk;  // 125 MHz

    rs_dual_encoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_mode(in_mode), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;

    logic [9:0] msg [0:K-1];
    logic [9:0] got [0:NM-1];
    logic       gsop [0:NM-1];
    logic       geop [0:NM-1];
    int nout, gap_err, hold_err;

    typedef struct packed {
        logic       mode;
        logic [1:0] kind;
        logic [15:0] seed;
        logic [3:0] stall;
        logic [9:0] exp_len;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{mode: 1'b0, kind: 2'd0, seed: 16'h1234, stall: 4'd0, exp_len: 10'd528},
        '{mode: 1'b1, kind: 2'd0, seed: 16'hbeef, stall: 4'd0, exp_len: 10'd544},
        '{mode: 1'b1, kind: 2'd2, seed: 16'h0001, stall: 4'd3, exp_len: 10'd544},
        '{mode: 1'b0, kind: 2'd3, seed: 16'd513,  stall: 4'd5, exp_len: 10'd528},
        '{mode: 1'b0, kind: 2'd1, seed: 16'h0000, stall: 4'd0, exp_len: 10'd528},
        '{mode: 1'b1, kind: 2'd3, seed: 16'd0,    stall: 4'd2, exp_len: 10'd544}
    };

    function automatic logic [9:0] fmul(logic [9:0] a, logic [9:0] b);
        logic [9:0] p = '0;
        logic [9:0] x = a;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) p ^= x;
            x = x[9] ? ((x << 1) ^ 10'h009) : (x << 1);
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic make_msg(input logic [1:0] kind, input logic [15:0] seed);
        logic [31:0] s = {16'h9e37, seed} | 32'd1;
        for (int i = 0; i < K; i++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            case (kind)
                2'd0: msg[i] = s[9:0];
                2'd1: msg[i] = '0;
                2'd2: msg[i] = 10'h3ff;
                default: msg[i] = (i == int'(seed)) ? 10'h2a5 : 10'h000;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_cw(input bit mode, input int stall, input bit flip, input bit midsop);
        int idx = 0, cyc = 0;
        bit done = 0, pend = 0;
        logic [9:0] held = '0;
        nout = 0; gap_err = 0; hold_err = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            out_ready = !(stall != 0 && (cyc % stall) == stall - 1);
            if (idx < K) begin
                in_valid = 1'b1;
                in_data  = msg[idx];
                in_sop   = (idx == 0) || (midsop && idx == 100);
                in_mode  = (flip && idx > 0) ? ~mode : mode;
            end else begin
                in_valid = 1'b0;
                in_sop   = 1'b0;
            end
            #2;
            if (pend) begin
                if (out_data !== held || out_valid !== 1'b1) hold_err++;
                pend = 0;
            end
            if (idx >= K && (in_ready !== 1'b0 || out_valid !== 1'b1)) gap_err++;
            if (out_valid && out_ready) begin
                got[nout] = out_data; gsop[nout] = out_sop; geop[nout] = out_eop;
                nout++;
                if (out_eop || nout >= NM) done = 1;
            end else if (out_valid && !out_ready && idx >= K) begin
                pend = 1; held = out_data;
            end
            if (in_valid && in_ready) idx++;
            cyc++;
        end
        if (!done) check(0, "watchdog", cyc, 0);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; out_ready = 1'b1;
    endtask

    task automatic check_cw(input bit mode, input string tag);
        int npar = mode ? 30 : 14;
        int n    = K + npar;
        logic [9:0] g [0:30];
        logic [9:0] c [0:NM-1];
        logic [9:0] root;
        int bad;
        for (int i = 0; i <= 30; i++) g[i] = '0;
        g[0] = 10'd1; root = 10'd1;
        for (int r = 0; r < npar; r++) begin
            for (int i = 30; i >= 1; i--) g[i] = g[i-1] ^ fmul(g[i], root);
            g[0] = fmul(g[0], root);
            root = fmul(root, 10'd2);
        end
        check(nout == n, {"R8 length ", tag}, nout, n);
        bad = 0;
        for (int i = 0; i < nout; i++) begin
            if (gsop[i] !== (i == 0)) bad++;
            if (geop[i] !== (i == n - 1)) bad++;
        end
        check(bad == 0, {"R8 markers ", tag}, bad, 0);
        bad = 0;
        for (int i = 0; i < K; i++) if (got[i] !== msg[i]) bad++;
        check(bad == 0, {"R2 passthrough ", tag}, bad, 0);
        for (int i = 0; i < NM; i++) c[i] = (i < K) ? msg[i] : 10'h000;
        for (int i = 0; i < K; i++) begin
            logic [9:0] f = c[i];
            for (int j = 1; j <= npar; j++) c[i+j] ^= fmul(f, g[npar-j]);
        end
        bad = 0;
        for (int j = 0; j < npar; j++) if (K + j >= nout || got[K+j] !== c[K+j]) bad++;
        check(bad == 0, mode ? {"R5 parity ", tag} : {"R4 parity ", tag}, bad, 0);
        bad = 0; root = 10'd1;
        for (int r = 0; r < npar; r++) begin
            logic [9:0] s = '0;
            for (int i = 0; i < nout; i++) s = fmul(s, root) ^ got[i];
            if (s != 0) bad++;
            root = fmul(root, 10'd2);
        end
        check(bad == 0, {"R12 roots ", tag}, bad, 0);
        check(gap_err == 0, {"R6 no gap ", tag}, gap_err, 0);
        check(hold_err == 0, {"R7 hold ", tag}, hold_err, 0);
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bad;
        do_reset();
        #2;
        check(out_valid === 1'b0, "R1 reset out_valid", out_valid, 0);
        check(in_ready === 1'b1, "R2 idle ready follows out_ready", in_ready, 1);

        // table walk: R4, R5, R7, R11 (back-to-back, no reset in between)
        foreach (VEC[v]) begin
            make_msg(VEC[v].kind, VEC[v].seed);
            run_cw(VEC[v].mode, int'(VEC[v].stall), 1'b0, 1'b0);
            check(nout == int'(VEC[v].exp_len), "R11 table length", nout, int'(VEC[v].exp_len));
            check_cw(VEC[v].mode, $sformatf("vec%0d", v));
        end

        // R9: unmarked symbols while idle are dropped
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_data = 10'h155; out_ready = 1'b1;
            #2;
            if (in_ready !== 1'b1 || out_valid !== 1'b0) bad++;
        end
        check(bad == 0, "R9 idle drop", bad, 0);
        make_msg(2'd0, 16'h4242);
        run_cw(1'b1, 0, 1'b0, 1'b0);
        check_cw(1'b1, "R9 after drop");

        // R3: mode flipped after start
        make_msg(2'd0, 16'h7777);
        run_cw(1'b0, 0, 1'b1, 1'b0);
        check_cw(1'b0, "R3 flip 0");
        run_cw(1'b1, 4, 1'b1, 1'b0);
        check_cw(1'b1, "R3 flip 1");

        // R10: second start marker mid-message
        make_msg(2'd0, 16'h0c0c);
        run_cw(1'b1, 0, 1'b0, 1'b1);
        check_cw(1'b1, "R10 mid sop");

        // R1: reset in the middle of a message
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_mode = 1'b1; in_data = 10'(i * 7 + 3);
        end
        do_reset();
        #2;
        check(out_valid === 1'b0, "R1 reset mid codeword", out_valid, 0);
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b0; in_data = 10'h0ff;
        #2;
        check(out_valid === 1'b0, "R1 idle after reset", out_valid, 0);
        make_msg(2'd0, 16'h5a5a);
        run_cw(1'b0, 0, 1'b0, 1'b0);
        check_cw(1'b0, "R1 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule